// File: doc/BRIEF.md
# Serial Transmit Path with Priority Queue

This block is the transmit half of one asynchronous serial channel. The host pushes ordinary bytes into a deep transmit queue and urgent bytes into a small priority queue. A one-byte holding register sits between the queues and the shift register. Whenever the holding register is free and the priority queue has data, it takes that byte first. The shift register then serialises the byte with the configured character framing, advancing one bit for each pulse on the bit-rate enable input.

Both byte inputs use valid/ready handshakes. A byte is accepted on a rising clock edge where valid and ready are both high. Ready drops only when that queue is full, and the sender must hold valid and data until it sees ready. Control and framing inputs are plain levels that the block samples every cycle. Framing is captured when a character starts, so it should change only while the shifter is idle.

The transmit-enable input gates only the step from the ordinary queue into the holding register. A byte already in the holding register, and one already shifting, still go out. The break input forces the line low. With flow control on, the CTS input gates the start of each new character. Loopback sends the serial stream to an internal receive pin and leaves the external line idle.

Top module: `uart_tx_prio`

## Requirements
- R1: The ordinary queue holds FIFO_DEPTH (255) bytes. `fifo_level` reports how many bytes it holds. `in_ready` is low only while it is full, and a byte offered while it is full changes nothing.
- R2: The priority queue holds PRIO_DEPTH (32) bytes. `prio_level` bit 7 is the pending flag, set while the queue holds any byte. Bits 6:0 give its fill. `pri_ready` is low only while it is full.
- R3: When the holding register is free, a pending priority byte is loaded before any byte of the ordinary queue. Bytes of each queue leave in the order they arrived.
- R4: While `tx_enable` is low, no byte moves from the ordinary queue to the holding register. Priority bytes still move. The byte in the holding register and the byte in the shifter still complete, so up to two characters go out after the disable.
- R5: A character is a start bit (0), then 7 or 8 data bits LSB first (8 when `data8`=1), then an optional parity bit, then 1 stop bit (2 when `two_stop`=1) at level 1. A character starts on a `baud_tick` cycle, and each bit lasts exactly one tick. The idle line is 1.
- R6: With `par_en`=1, the parity bit makes the count of ones over data and parity even when `par_even`=1 and odd when `par_even`=0. With `par_en`=0, `par_even` has no effect on the line.
- R7: While `send_break`=1, `txd` is 0 and no new character starts. Queued bytes are kept and go out after the break is cleared.
- R8: With `cts_flow_en`=1 and `cts_in`=0, no new character starts. A character already shifting completes.
- R9: With `loop_back`=1, the serial stream appears on `loop_rxd` and `txd` stays 1. With `loop_back`=0, `loop_rxd` is 1.
- R10: `queue_empty` is 1 when both queues and the holding register are empty. `shift_empty` is 1 when no character is shifting. `drained` is 1 only when both are 1. `dtr_out` and `rts_out` follow `dtr_req` and `rts_req`.
- R11: After reset, both queues are empty, `txd` is 1, both ready outputs are 1, and `queue_empty`, `shift_empty` and `drained` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Bit-rate enable, one pulse per bit time |
| in_valid | input | 1 | Ordinary byte offered |
| in_data | input | 8 | Ordinary byte |
| in_ready | output | 1 | Ordinary queue can accept |
| pri_valid | input | 1 | Priority byte offered |
| pri_data | input | 8 | Priority byte |
| pri_ready | output | 1 | Priority queue can accept |
| tx_enable | input | 1 | Allow ordinary queue to feed the holding register |
| send_break | input | 1 | Hold the line low |
| loop_back | input | 1 | Route the stream to loop_rxd |
| dtr_req | input | 1 | DTR request |
| rts_req | input | 1 | RTS request |
| cts_flow_en | input | 1 | Gate character starts on CTS |
| cts_in | input | 1 | CTS asserted (1) |
| data8 | input | 1 | 8 data bits (else 7) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity (else odd) |
| two_stop | input | 1 | Two stop bits (else one) |
| txd | output | 1 | Serial line |
| loop_rxd | output | 1 | Internal loopback receive line |
| dtr_out | output | 1 | DTR output |
| rts_out | output | 1 | RTS output |
| fifo_level | output | 8 | Ordinary queue fill |
| prio_level | output | 8 | Bit 7 pending flag, bits 6:0 priority fill |
| queue_empty | output | 1 | Queues and holding register empty |
| shift_empty | output | 1 | Shifter idle |
| drained | output | 1 | Queue and shifter both empty |

## Verification
The hardest state to reach is one where a character is shifting, another byte waits in the holding register, and the ordinary queue still has data. This is the state in which a transmit disable or a priority arrival must act. The stimulus builds it in two ways. It holds CTS low with flow control enabled, so bytes stack in the holding register and both queues before CTS is released. It also drops transmit enable a few cycles after a burst of pushes, while the first character is still on the line. The bench then decodes the order and framing of every character on the line and compares it with bytes and frames it computes itself.

// File: rtl/uart_txp_pkg.sv
package uart_txp_pkg;

  localparam int FRAME_W = 12;

  typedef struct packed {
    logic data8;
    logic par_en;
    logic par_even;
    logic two_stop;
  } frame_cfg_t;

  // Bit 0 is sent first; unused upper bits stay 1 (stop level).
  function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d,
                                                      input frame_cfg_t c);
    logic [FRAME_W-1:0] f;
    logic [3:0]         k;
    logic [7:0]         used;
    f    = '1;
    f[0] = 1'b0;
    k    = 4'd1;
    used = c.data8 ? d : {1'b0, d[6:0]};
    for (int i = 0; i < 8; i++) begin
      if (i < 7 || c.data8) begin
        f[k] = d[i];
        k    = k + 4'd1;
      end
    end
    if (c.par_en) f[k] = c.par_even ? ^used : ~^used;
    return f;
  endfunction

  function automatic logic [3:0] frame_bits(input frame_cfg_t c);
    return 4'd9 + {3'd0, c.data8} + {3'd0, c.par_en} + {3'd0, c.two_stop};
  endfunction

endpackage

// File: rtl/uart_txp_fifo.sv
module uart_txp_fifo #(
  parameter int DEPTH = 255,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [W-1:0]  wr_data,
  output logic          wr_ready,
  input  logic          rd_pop,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push;

  assign wr_ready = (count != CW'(DEPTH));
  assign push     = wr_valid && wr_ready;
  assign empty    = (count == '0);
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, rd_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: the consumer never pops an empty queue
  a_r1_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> count != '0);
  // R1: a full queue refuses a push, so the level cannot rise past DEPTH
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !rd_pop) |=> count == CW'(DEPTH));

endmodule

// File: rtl/uart_txp_shifter.sv
module uart_txp_shifter
  import uart_txp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start_ok,
  input  logic       hold_valid,
  input  logic [7:0] hold_data,
  input  frame_cfg_t cfg,
  output logic       take,
  output logic       busy,
  output logic       line
);

  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;

  assign take = tick && !busy && hold_valid && start_ok;
  assign line = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      busy  <= 1'b0;
    end else if (take) begin
      shreg <= build_frame(hold_data, cfg);
      left  <= frame_bits(cfg);
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (left == 4'd1) begin
        busy <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - 4'd1;
      end
    end
  end

  // R5: every character opens with a low start bit
  a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line == 1'b0);
  // R5: a bit holds its level between ticks
  a_r5_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(line) || !busy);

endmodule

// File: rtl/uart_tx_prio.sv
module uart_tx_prio
  import uart_txp_pkg::*;
#(
  parameter int FIFO_DEPTH = 255,
  parameter int PRIO_DEPTH = 32,
  localparam int FCW = $clog2(FIFO_DEPTH + 1),
  localparam int PCW = $clog2(PRIO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           baud_tick,
  input  logic           in_valid,
  input  logic [7:0]     in_data,
  output logic           in_ready,
  input  logic           pri_valid,
  input  logic [7:0]     pri_data,
  output logic           pri_ready,
  input  logic           tx_enable,
  input  logic           send_break,
  input  logic           loop_back,
  input  logic           dtr_req,
  input  logic           rts_req,
  input  logic           cts_flow_en,
  input  logic           cts_in,
  input  logic           data8,
  input  logic           par_en,
  input  logic           par_even,
  input  logic           two_stop,
  output logic           txd,
  output logic           loop_rxd,
  output logic           dtr_out,
  output logic           rts_out,
  output logic [FCW-1:0] fifo_level,
  output logic [7:0]     prio_level,
  output logic           queue_empty,
  output logic           shift_empty,
  output logic           drained
);

  logic [7:0]     fifo_rd, pri_rd, hold_data;
  logic           fifo_empty, pri_empty, fifo_pop, pri_pop;
  logic [PCW-1:0] pri_cnt;
  logic           hold_valid, take, busy, line, start_ok;
  frame_cfg_t     cfg;

  uart_txp_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_main_q (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_data(in_data), .wr_ready(in_ready),
    .rd_pop(fifo_pop), .rd_data(fifo_rd), .count(fifo_level), .empty(fifo_empty)
  );

  uart_txp_fifo #(.DEPTH(PRIO_DEPTH), .W(8)) u_prio_q (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(pri_valid), .wr_data(pri_data), .wr_ready(pri_ready),
    .rd_pop(pri_pop), .rd_data(pri_rd), .count(pri_cnt), .empty(pri_empty)
  );

  // Holding register: priority first, ordinary queue only while enabled
  assign pri_pop  = !hold_valid && !pri_empty;
  assign fifo_pop = !hold_valid && pri_empty && tx_enable && !fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
    end else if (pri_pop) begin
      hold_valid <= 1'b1;
      hold_data  <= pri_rd;
    end else if (fifo_pop) begin
      hold_valid <= 1'b1;
      hold_data  <= fifo_rd;
    end else if (take) begin
      hold_valid <= 1'b0;
    end
  end

  assign cfg      = '{data8: data8, par_en: par_en, par_even: par_even, two_stop: two_stop};
  assign start_ok = !send_break && (!cts_flow_en || cts_in);

  uart_txp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .start_ok(start_ok),
    .hold_valid(hold_valid), .hold_data(hold_data), .cfg(cfg),
    .take(take), .busy(busy), .line(line)
  );

  assign txd         = send_break ? 1'b0 : (loop_back ? 1'b1 : line);
  assign loop_rxd    = loop_back ? (send_break ? 1'b0 : line) : 1'b1;
  assign dtr_out     = dtr_req;
  assign rts_out     = rts_req;
  assign prio_level  = {!pri_empty, 7'(pri_cnt)};
  assign queue_empty = fifo_empty && pri_empty && !hold_valid;
  assign shift_empty = !busy;
  assign drained     = queue_empty && shift_empty;

  // R3: a free holding register drains one pending priority byte per load
  a_r3_prio_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_valid && !pri_empty && !(pri_valid && pri_ready))
      |=> pri_cnt == $past(pri_cnt) - 1'b1);
  // R4: with transmit disabled the ordinary queue does not shrink
  a_r4_disable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !(in_valid && in_ready)) |=> fifo_level == $past(fifo_level));
  // R7: no character starts during break
  a_r7_break_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (send_break && !busy) |=> !busy);
  // R8: CTS low with flow control keeps the shifter idle
  a_r8_cts_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_flow_en && !cts_in && !busy) |=> !busy);

endmodule

// File: tb/uart_tx_prio_bench.sv
`timescale 1ns/1ps
module uart_tx_prio_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       in_valid = 1'b0, pri_valid = 1'b0;
  logic [7:0] in_data = '0, pri_data = '0;
  logic       in_ready, pri_ready;
  logic       tx_enable = 1'b1, send_break = 1'b0, loop_back = 1'b0;
  logic       dtr_req = 1'b0, rts_req = 1'b0, cts_flow_en = 1'b0, cts_in = 1'b1;
  logic       data8 = 1'b1, par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
  logic       txd, loop_rxd, dtr_out, rts_out, queue_empty, shift_empty, drained;
  logic [7:0] fifo_level, prio_level;

  int checks = 0;
  int failures = 0;

  uart_tx_prio u_uart_tx_prio (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pri_valid(pri_valid), .pri_data(pri_data), .pri_ready(pri_ready),
    .tx_enable(tx_enable), .send_break(send_break), .loop_back(loop_back),
    .dtr_req(dtr_req), .rts_req(rts_req), .cts_flow_en(cts_flow_en), .cts_in(cts_in),
    .data8(data8), .par_en(par_en), .par_even(par_even), .two_stop(two_stop),
    .txd(txd), .loop_rxd(loop_rxd), .dtr_out(dtr_out), .rts_out(rts_out),
    .fifo_level(fifo_level), .prio_level(prio_level),
    .queue_empty(queue_empty), .shift_empty(shift_empty), .drained(drained)
  );

  always #2 clk = ~clk;

  // {data8, par_en, par_even, two_stop, data[7:0]}
  localparam logic [11:0] VEC [7] = '{
    12'h855, 12'hEA7, 12'hCA7, 12'h7C3, 12'h23C, 12'h900, 12'hCFF
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] want(input logic [7:0] d, input logic [3:0] c);
    logic [11:0] f = '1;
    int pos = 1;
    int ones = 0;
    f[0] = 1'b0;
    for (int i = 0; i < (c[3] ? 8 : 7); i++) begin
      f[pos] = d[i];
      ones += int'(d[i]);
      pos++;
    end
    if (c[2]) f[pos] = c[1] ? ones[0] : ~ones[0];
    return f;
  endfunction

  function automatic int want_len(input logic [3:0] c);
    return 9 + int'(c[3]) + int'(c[2]) + int'(c[0]);
  endfunction

  function automatic logic [11:0] lenmask(input int nb);
    return 12'hFFF >> (12 - nb);
  endfunction

  task automatic set_cfg(input logic [3:0] c);
    data8 = c[3]; par_en = c[2]; par_even = c[1]; two_stop = c[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 0; pri_valid = 0; tx_enable = 1; send_break = 0; loop_back = 0;
    cts_flow_en = 0; cts_in = 1; set_cfg(4'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input bit pri, input logic [7:0] d);
    @(negedge clk);
    if (pri) begin pri_valid = 1'b1; pri_data = d; end
    else     begin in_valid = 1'b1;  in_data = d;  end
    @(negedge clk);
    pri_valid = 1'b0;
    in_valid  = 1'b0;
  endtask

  task automatic capture(input bit from_loop, input int nb, output logic [11:0] bits);
    int guard = 0;
    bits = '1;
    @(negedge clk);
    while (((from_loop ? loop_rxd : txd) !== 1'b0) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    bits[0] = from_loop ? loop_rxd : txd;
    for (int i = 1; i < nb; i++) begin
      @(negedge clk);
      bits[i] = from_loop ? loop_rxd : txd;
    end
  endtask

  task automatic expect_char(input bit from_loop, input logic [7:0] d, input string tag);
    logic [11:0] got, exp;
    exp = want(d, 4'b1000);
    capture(from_loop, 10, got);
    check((got & lenmask(10)) == (exp & lenmask(10)), tag, int'(got), int'(exp));
  endtask

  task automatic wait_drained();
    int guard = 0;
    while (drained !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] got, exp;
    int lows;

    // R11: reset state
    do_reset();
    check(txd == 1'b1, "R11 txd idle", int'(txd), 1);
    check(fifo_level == 8'd0 && prio_level == 8'd0, "R11 levels", int'({fifo_level, prio_level}), 0);
    check(in_ready && pri_ready, "R11 ready", int'({in_ready, pri_ready}), 3);
    check(queue_empty && shift_empty && drained, "R11 empty flags",
          int'({queue_empty, shift_empty, drained}), 7);

    // R10: modem outputs follow requests
    dtr_req = 1'b1; rts_req = 1'b0;
    @(negedge clk);
    check(dtr_out == 1'b1 && rts_out == 1'b0, "R10 dtr/rts", int'({dtr_out, rts_out}), 2);
    dtr_req = 1'b0; rts_req = 1'b1;
    @(negedge clk);
    check(dtr_out == 1'b0 && rts_out == 1'b1, "R10 dtr/rts swap", int'({dtr_out, rts_out}), 1);

    // R5 / R6: framing table
    foreach (VEC[v]) begin
      set_cfg(VEC[v][11:8]);
      exp = want(VEC[v][7:0], VEC[v][11:8]);
      fork
        capture(1'b0, want_len(VEC[v][11:8]), got);
        push(1'b0, VEC[v][7:0]);
      join
      check((got & lenmask(want_len(VEC[v][11:8]))) == (exp & lenmask(want_len(VEC[v][11:8]))),
            $sformatf("R5 R6 frame vector %0d", v), int'(got), int'(exp));
      wait_drained();
    end

    // R10: drained only when queue and shifter both empty
    set_cfg(4'b1000);
    push(1'b0, 8'h81);
    repeat (3) @(negedge clk);
    check(shift_empty == 1'b0 && drained == 1'b0, "R10 busy not drained",
          int'({shift_empty, drained}), 0);
    wait_drained();
    check(queue_empty && shift_empty && drained, "R10 drained after frame",
          int'({queue_empty, shift_empty, drained}), 7);

    // R3 / R2: priority preemption with CTS stalling the shifter
    do_reset();
    cts_flow_en = 1'b1; cts_in = 1'b0;
    push(1'b0, 8'hA1);
    push(1'b0, 8'hB2);
    push(1'b0, 8'hC3);
    push(1'b1, 8'h11);
    push(1'b1, 8'h22);
    @(negedge clk);
    check(prio_level == 8'h82, "R2 pending flag and fill", int'(prio_level), 8'h82);
    check(fifo_level == 8'd2, "R1 level with stall", int'(fifo_level), 2);
    check(queue_empty == 1'b0, "R10 queue not empty", int'(queue_empty), 0);
    cts_in = 1'b1;
    expect_char(1'b0, 8'hA1, "R3 order 1 (held byte)");
    expect_char(1'b0, 8'h11, "R3 order 2 (priority)");
    expect_char(1'b0, 8'h22, "R3 order 3 (priority)");
    expect_char(1'b0, 8'hB2, "R3 order 4 (normal)");
    expect_char(1'b0, 8'hC3, "R3 order 5 (normal)");
    wait_drained();
    check(prio_level == 8'h00, "R2 pending cleared", int'(prio_level), 0);

    // R4: disable lets holding and shifting bytes drain only
    do_reset();
    fork
      begin
        expect_char(1'b0, 8'h5A, "R4 drain first");
        expect_char(1'b0, 8'h6B, "R4 drain second");
      end
      begin
        push(1'b0, 8'h5A);
        push(1'b0, 8'h6B);
        push(1'b0, 8'h7C);
        repeat (2) @(negedge clk);
        tx_enable = 1'b0;
      end
    join
    lows = 0;
    repeat (40) begin @(negedge clk); if (txd == 1'b0) lows++; end
    check(lows == 0, "R4 no third char", lows, 0);
    check(fifo_level == 8'd1 && shift_empty == 1'b1, "R4 byte kept in queue",
          int'({fifo_level, 7'd0, shift_empty}), 'h101);
    check(drained == 1'b0, "R10 not drained with data", int'(drained), 0);
    fork
      expect_char(1'b0, 8'h3E, "R4 priority moves while disabled");
      push(1'b1, 8'h3E);
    join
    tx_enable = 1'b1;
    expect_char(1'b0, 8'h7C, "R4 resumes after enable");
    wait_drained();

    // R7: break holds line low and blocks starts
    do_reset();
    send_break = 1'b1;
    push(1'b0, 8'h96);
    lows = 0;
    repeat (20) begin @(negedge clk); if (txd == 1'b0) lows++; end
    check(lows == 20, "R7 line low in break", lows, 20);
    check(shift_empty == 1'b1 && queue_empty == 1'b0, "R7 no start, byte kept",
          int'({shift_empty, queue_empty}), 2);
    @(negedge clk);
    send_break = 1'b0;
    expect_char(1'b0, 8'h96, "R7 byte sent after break");

    // R8: CTS stops new starts, running char completes
    do_reset();
    cts_flow_en = 1'b1;
    fork
      expect_char(1'b0, 8'hE4, "R8 running char completes");
      begin
        push(1'b0, 8'hE4);
        push(1'b0, 8'h1F);
        cts_in = 1'b0;
      end
    join
    lows = 0;
    repeat (30) begin @(negedge clk); if (txd == 1'b0) lows++; end
    check(lows == 0 && shift_empty == 1'b1, "R8 no start with CTS low",
          lows, 0);
    cts_in = 1'b1;
    expect_char(1'b0, 8'h1F, "R8 start after CTS");

    // R9: loopback
    do_reset();
    loop_back = 1'b1;
    lows = 0;
    fork
      expect_char(1'b1, 8'hC6, "R9 stream on loop_rxd");
      begin
        push(1'b0, 8'hC6);
        repeat (14) begin @(negedge clk); if (txd == 1'b0) lows++; end
      end
    join
    check(lows == 0, "R9 txd idle in loopback", lows, 0);
    loop_back = 1'b0;
    @(negedge clk);
    check(loop_rxd == 1'b1, "R9 loop_rxd idle when off", int'(loop_rxd), 1);

    // R1: ordinary queue full
    do_reset();
    tx_enable = 1'b0;
    for (int i = 0; i < 255; i++) push(1'b0, 8'(i));
    check(fifo_level == 8'd255, "R1 full level", int'(fifo_level), 255);
    check(in_ready == 1'b0, "R1 ready low when full", int'(in_ready), 0);
    push(1'b0, 8'hEE);
    check(fifo_level == 8'd255, "R1 extra push ignored", int'(fifo_level), 255);
    tx_enable = 1'b1;
    expect_char(1'b0, 8'h00, "R1 first byte out in order");

    // R2: priority queue full
    do_reset();
    cts_flow_en = 1'b1; cts_in = 1'b0;
    for (int i = 0; i < 33; i++) push(1'b1, 8'(i + 64));
    check(prio_level == 8'hA0, "R2 full fill 32 with pending", int'(prio_level), 8'hA0);
    check(pri_ready == 1'b0, "R2 ready low when full", int'(pri_ready), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule